// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It uses 4 KB pages and a page table held in memory with two levels. A root input holds the physical frame number of the top-level table. When a request is accepted, the walker does the following:

1. It uses the top ten bits of the virtual address to pick an entry in the top-level table, and fetches that entry over a simple memory read port.
2. It uses the next ten bits to pick an entry in the second-level table that the first entry points at, and fetches that entry.
3. It checks the present bit and the writable bit of each entry.
4. It returns either the frame from the last entry, joined with the untouched 12-bit page offset, or a fault together with its cause.

The translation uses no adder and no bounds compare. The frame number from the table simply replaces the virtual page number.

Only one walk runs at a time. The request side is ready only while the walker is idle, so a new request waits until the current walk has ended. Each memory read is presented with valid/ready and held until the memory accepts it. The data comes back later on its own valid strobe, after any number of cycles. A walk ends with a one-cycle response pulse.

Top module: `pgwalk_top`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0 and mem_req_valid is 0.
- R2: The first memory read of a walk is at address {root_frame, vaddr[31:22], 2'b00}.
- R3: The second memory read is at address {E1[31:12], vaddr[21:12], 2'b00}, where E1 is the top-level entry that was returned.
- R4: A walk without a fault returns rsp_fault = 0 and rsp_paddr = {E2[31:12], vaddr[11:0]}, where E2 is the second-level entry.
- R5: An entry whose bit 0 (present) is 0 ends the walk with rsp_fault = 1, rsp_fault_kind = 0 and rsp_paddr = 0. If this happens at the top level, no second read is issued.
- R6: A write request (req_write = 1) that meets an entry whose bit 1 (writable) is 0, at either level, ends the walk with rsp_fault = 1 and rsp_fault_kind = 1. The present bit is checked first. A read request ignores bit 1.
- R7: While mem_req_valid is 1 and mem_req_ready is 0, the read request stays asserted with an unchanged address. After the memory accepts it, mem_req_valid drops.
- R8: req_ready is 0 from the cycle after a request is accepted until the walk ends. A request held during that time starts no second walk.
- R9: rsp_valid is a one-cycle pulse. It is high in the cycle after the clock edge that captures the last entry needed. In the cycle after that, req_ready is 1 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| root_frame | input | 20 | Physical frame number of the top-level table |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle; request accepted when both are high |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read access |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 32 | Physical byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Entry read from memory |
| rsp_valid | output | 1 | Translation result valid (one cycle) |
| rsp_paddr | output | 32 | Physical address; 0 on a fault |
| rsp_fault | output | 1 | Walk ended in a fault |
| rsp_fault_kind | output | 1 | 0 = not present, 1 = write to a read-only page |

## Verification
Some internal faults show up early. A wrong level counter or a wrong stored table frame shows up on mem_req_addr at the very next read. The bench compares every read address, so the cycle in which the read is presented exposes it.

A corrupted latched virtual address or access type appears either in the second read's index or in the returned offset and fault cause. Both are seen by the end of the same walk.

A state machine that leaves the idle state wrongly, or fails to return to it, shows up in other ways. It can appear as req_ready being low or high at the wrong time. It can appear as a missing or doubled response pulse. It can appear as an extra memory read after a top-level fault. All of these are visible within one or two cycles of the step that goes wrong.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RD_REQ  = 2'd1,
        ST_RD_WAIT = 2'd2,
        ST_DONE    = 2'd3
    } walk_state_e;

    typedef enum logic {
        FLT_ABSENT = 1'b0,
        FLT_PROT   = 1'b1
    } fault_e;

    localparam int PRESENT_BIT = 0;
    localparam int WRITE_BIT   = 1;

endpackage

// File: rtl/pgwalk_addr_gen.sv
module pgwalk_addr_gen #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 12,
    parameter int IDX_W  = 10,
    parameter int LEVELS = 2,
    localparam int FRAME_W = ADDR_W - OFF_W,
    localparam int LVL_W   = (LEVELS > 1) ? $clog2(LEVELS) : 1,
    localparam int ENT_SH  = OFF_W - IDX_W
) (
    input  logic [LVL_W-1:0]   level,
    input  logic [FRAME_W-1:0] table_frame,
    input  logic [ADDR_W-1:0]  vaddr,
    output logic [ADDR_W-1:0]  entry_addr
);

    logic [IDX_W-1:0] idx_arr [LEVELS];
    logic             unused_offset;

    for (genvar g = 0; g < LEVELS; g++) begin : g_idx
        assign idx_arr[g] = vaddr[ADDR_W-1-g*IDX_W -: IDX_W];
    end

    assign unused_offset = ^vaddr[OFF_W-1:0];
    assign entry_addr    = {table_frame, idx_arr[level], {ENT_SH{1'b0}}};

endmodule

// File: rtl/pgwalk_entry_chk.sv
module pgwalk_entry_chk
    import pgwalk_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 12,
    localparam int FRAME_W = ADDR_W - OFF_W
) (
    input  logic [ADDR_W-1:0]  entry,
    input  logic               is_write,
    output logic               present,
    output logic               permit,
    output logic [FRAME_W-1:0] frame
);

    logic unused_flags;

    assign present      = entry[PRESENT_BIT];
    assign permit       = !is_write || entry[WRITE_BIT];
    assign frame        = entry[ADDR_W-1:OFF_W];
    assign unused_flags = ^entry[OFF_W-1:WRITE_BIT+1];

endmodule

// File: rtl/pgwalk_ctrl.sv
module pgwalk_ctrl
    import pgwalk_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 12,
    parameter int LEVELS = 2,
    localparam int FRAME_W = ADDR_W - OFF_W,
    localparam int LVL_W   = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FRAME_W-1:0] root_frame,
    input  logic               req_valid,
    input  logic [ADDR_W-1:0]  req_vaddr,
    input  logic               req_write,
    input  logic               mem_req_ready,
    input  logic               mem_rsp_valid,
    input  logic               ent_present,
    input  logic               ent_permit,
    input  logic [FRAME_W-1:0] ent_frame,
    output logic               req_ready,
    output logic [LVL_W-1:0]   level,
    output logic [FRAME_W-1:0] table_frame,
    output logic [ADDR_W-1:0]  vaddr,
    output logic               is_write,
    output logic               mem_req_valid,
    output logic               rsp_valid,
    output logic [ADDR_W-1:0]  rsp_paddr,
    output logic               rsp_fault,
    output logic               rsp_fault_kind
);

    localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS - 1);

    typedef struct packed {
        walk_state_e        state;
        logic [LVL_W-1:0]   level;
        logic [ADDR_W-1:0]  vaddr;
        logic               is_write;
        logic [FRAME_W-1:0] frame;
        logic               fault;
        fault_e             kind;
        logic [ADDR_W-1:0]  paddr;
    } walk_regs_t;

    walk_regs_t walk_d, walk_q;

    always_comb begin
        walk_d = walk_q;
        unique case (walk_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    walk_d.state    = ST_RD_REQ;
                    walk_d.level    = '0;
                    walk_d.vaddr    = req_vaddr;
                    walk_d.is_write = req_write;
                    walk_d.frame    = root_frame;
                    walk_d.fault    = 1'b0;
                    walk_d.kind     = FLT_ABSENT;
                    walk_d.paddr    = '0;
                end
            end
            ST_RD_REQ: begin
                if (mem_req_ready) begin
                    walk_d.state = ST_RD_WAIT;
                end
            end
            ST_RD_WAIT: begin
                if (mem_rsp_valid) begin
                    if (!ent_present) begin
                        walk_d.state = ST_DONE;
                        walk_d.fault = 1'b1;
                        walk_d.kind  = FLT_ABSENT;
                        walk_d.paddr = '0;
                    end else if (!ent_permit) begin
                        walk_d.state = ST_DONE;
                        walk_d.fault = 1'b1;
                        walk_d.kind  = FLT_PROT;
                        walk_d.paddr = '0;
                    end else if (walk_q.level == LAST_LVL) begin
                        walk_d.state = ST_DONE;
                        walk_d.fault = 1'b0;
                        walk_d.paddr = {ent_frame, walk_q.vaddr[OFF_W-1:0]};
                    end else begin
                        walk_d.state = ST_RD_REQ;
                        walk_d.level = walk_q.level + 1'b1;
                        walk_d.frame = ent_frame;
                    end
                end
            end
            ST_DONE: begin
                walk_d.state = ST_IDLE;
            end
            default: walk_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            walk_q <= '{state: ST_IDLE, level: '0, vaddr: '0, is_write: 1'b0,
                        frame: '0, fault: 1'b0, kind: FLT_ABSENT, paddr: '0};
        end else begin
            walk_q <= walk_d;
        end
    end

    assign req_ready      = (walk_q.state == ST_IDLE);
    assign mem_req_valid  = (walk_q.state == ST_RD_REQ);
    assign rsp_valid      = (walk_q.state == ST_DONE);
    assign level          = walk_q.level;
    assign table_frame    = walk_q.frame;
    assign vaddr          = walk_q.vaddr;
    assign is_write       = walk_q.is_write;
    assign rsp_paddr      = walk_q.paddr;
    assign rsp_fault      = walk_q.fault;
    assign rsp_fault_kind = walk_q.kind;

endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 12,
    parameter int IDX_W  = 10,
    parameter int LEVELS = 2,
    localparam int FRAME_W = ADDR_W - OFF_W,
    localparam int LVL_W   = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FRAME_W-1:0] root_frame,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [ADDR_W-1:0]  req_vaddr,
    input  logic               req_write,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [ADDR_W-1:0]  mem_req_addr,
    input  logic               mem_rsp_valid,
    input  logic [ADDR_W-1:0]  mem_rsp_data,
    output logic               rsp_valid,
    output logic [ADDR_W-1:0]  rsp_paddr,
    output logic               rsp_fault,
    output logic               rsp_fault_kind
);

    logic [LVL_W-1:0]   cur_level;
    logic [FRAME_W-1:0] cur_frame;
    logic [ADDR_W-1:0]  held_vaddr;
    logic               held_write;
    logic               ent_present;
    logic               ent_permit;
    logic [FRAME_W-1:0] ent_frame;

    pgwalk_ctrl #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W),
        .LEVELS (LEVELS)
    ) i_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .root_frame     (root_frame),
        .req_valid      (req_valid),
        .req_vaddr      (req_vaddr),
        .req_write      (req_write),
        .mem_req_ready  (mem_req_ready),
        .mem_rsp_valid  (mem_rsp_valid),
        .ent_present    (ent_present),
        .ent_permit     (ent_permit),
        .ent_frame      (ent_frame),
        .req_ready      (req_ready),
        .level          (cur_level),
        .table_frame    (cur_frame),
        .vaddr          (held_vaddr),
        .is_write       (held_write),
        .mem_req_valid  (mem_req_valid),
        .rsp_valid      (rsp_valid),
        .rsp_paddr      (rsp_paddr),
        .rsp_fault      (rsp_fault),
        .rsp_fault_kind (rsp_fault_kind)
    );

    pgwalk_addr_gen #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W),
        .IDX_W  (IDX_W),
        .LEVELS (LEVELS)
    ) i_addr_gen (
        .level       (cur_level),
        .table_frame (cur_frame),
        .vaddr       (held_vaddr),
        .entry_addr  (mem_req_addr)
    );

    pgwalk_entry_chk #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W)
    ) i_entry_chk (
        .entry    (mem_rsp_data),
        .is_write (held_write),
        .present  (ent_present),
        .permit   (ent_permit),
        .frame    (ent_frame)
    );

endmodule

// File: rtl/pgwalk_chk.sv
module pgwalk_chk #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [OFF_W-1:0]  req_offset,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              mem_rsp_valid,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] rsp_paddr,
    input logic              rsp_fault
);

    logic [OFF_W-1:0] off_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_q <= '0;
        end else if (req_valid && req_ready) begin
            off_q <= req_offset;
        end
    end

    assert_hold_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    assert_drop_after_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_ready) |=> !mem_req_valid);

    assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    assert_no_accept_in_walk_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid || rsp_valid) |-> !req_ready);

    assert_rsp_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready));

    assert_rsp_after_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rsp_valid) |-> $past(mem_rsp_valid));

    assert_fault_zero_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_paddr == '0));

    assert_offset_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> (rsp_paddr[OFF_W-1:0] == off_q));

endmodule

bind pgwalk_top pgwalk_chk #(
    .ADDR_W (ADDR_W),
    .OFF_W  (OFF_W)
) i_pgwalk_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_offset    (req_vaddr[OFF_W-1:0]),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .rsp_valid     (rsp_valid),
    .rsp_paddr     (rsp_paddr),
    .rsp_fault     (rsp_fault)
);

// File: tb/test_pgwalk_top.sv
module test_pgwalk_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] root_frame = 20'h00001;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic        rsp_fault;
    logic        rsp_fault_kind;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;

    pgwalk_top i_pgwalk_top (
        .clk            (clk),
        .rst_n          (rst_n),
        .root_frame     (root_frame),
        .req_valid      (req_valid),
        .req_ready      (req_ready),
        .req_vaddr      (req_vaddr),
        .req_write      (req_write),
        .mem_req_valid  (mem_req_valid),
        .mem_req_ready  (mem_req_ready),
        .mem_req_addr   (mem_req_addr),
        .mem_rsp_valid  (mem_rsp_valid),
        .mem_rsp_data   (mem_rsp_data),
        .rsp_valid      (rsp_valid),
        .rsp_paddr      (rsp_paddr),
        .rsp_fault      (rsp_fault),
        .rsp_fault_kind (rsp_fault_kind)
    );

    task automatic check(input logic ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Top-level entry i: present unless i%4==3, writable unless i%4==2, points to frame 0x100+i.
    // Second-level entry (i,j): present unless j%5==4, writable unless j%3==1.
    function automatic logic [31:0] mem_word(input logic [31:0] a);
        logic [19:0] fr;
        int          idx;
        int          i;
        fr  = a[31:12];
        idx = int'(a[11:2]);
        if (fr == root_frame) begin
            return {20'h00100 + 20'(idx), 10'b0, logic'(idx % 4 != 2), logic'(idx % 4 != 3)};
        end else if (fr >= 20'h00100 && fr < 20'h00500) begin
            i = int'(fr - 20'h00100);
            return {{10'(i), 10'(idx)} ^ 20'h5A5A5, 10'b0,
                    logic'(idx % 3 != 1), logic'(idx % 5 != 4)};
        end
        return 32'h0;
    endfunction

    task automatic walk(input int i, input int j, input logic wr);
        logic [31:0] va, exp_addr [2], got;
        logic [11:0] off;
        logic        p1, w1, p2, w2, exp_fault, exp_kind, done;
        logic [31:0] exp_pa;
        int          end_lvl, d, lat;
        off = 12'(i * 37 + j * 101 + (wr ? 5 : 0));
        if (j == 1023) off = 12'hFFF;
        if (j == 0)    off = 12'h000;
        va  = {10'(i), 10'(j), off};
        p1 = (i % 4 != 3); w1 = (i % 4 != 2);
        p2 = (j % 5 != 4); w2 = (j % 3 != 1);
        exp_addr[0] = {root_frame, 10'(i), 2'b00};
        exp_addr[1] = {20'h00100 + 20'(i), 10'(j), 2'b00};
        exp_pa = 32'h0; exp_kind = 1'b0; exp_fault = 1'b1; end_lvl = 1;
        if (!p1)            begin end_lvl = 0; exp_kind = 1'b0; end
        else if (wr && !w1) begin end_lvl = 0; exp_kind = 1'b1; end
        else if (!p2)       exp_kind = 1'b0;
        else if (wr && !w2) exp_kind = 1'b1;
        else begin
            exp_fault = 1'b0;
            exp_pa = {({10'(i), 10'(j)} ^ 20'h5A5A5), off};
        end
        d   = (i + j) % 3;
        lat = (i + 2 * j + (wr ? 1 : 0)) % 4;

        req_vaddr = va; req_write = wr; req_valid = 1'b1;
        check(req_ready == 1'b1, "R8 idle walker ready", 32'(req_ready), 32'h1);
        @(negedge clk);
        done = 1'b0;
        for (int lvl = 0; lvl < 2; lvl++) begin
            if (!done) begin
                check(mem_req_valid == 1'b1, lvl == 0 ? "R2 read issued" : "R3 read issued",
                      32'(mem_req_valid), 32'h1);
                check(mem_req_addr == exp_addr[lvl], lvl == 0 ? "R2 top address" : "R3 second address",
                      mem_req_addr, exp_addr[lvl]);
                got = mem_req_addr;
                for (int k = 0; k < d; k++) begin
                    @(negedge clk);
                    check(mem_req_valid && mem_req_addr == got, "R7 request held",
                          mem_req_addr, got);
                end
                mem_req_ready = 1'b1;
                @(negedge clk);
                mem_req_ready = 1'b0;
                check(mem_req_valid == 1'b0, "R7 drop after accept", 32'(mem_req_valid), 32'h0);
                for (int k = 0; k < lat; k++) @(negedge clk);
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = mem_word(got);
                @(negedge clk);
                mem_rsp_valid = 1'b0;
                mem_rsp_data  = 32'h0;
                check(req_ready == 1'b0, "R8 busy during walk", 32'(req_ready), 32'h0);
                if (lvl == end_lvl) done = 1'b1;
            end
        end
        check(rsp_valid == 1'b1, "R9 response timing", 32'(rsp_valid), 32'h1);
        check(mem_req_valid == 1'b0, "R5 no further read", 32'(mem_req_valid), 32'h0);
        check(rsp_fault == exp_fault, exp_fault ? "R5 fault flag" : "R4 no fault",
              32'(rsp_fault), 32'(exp_fault));
        check(rsp_paddr == exp_pa, exp_fault ? "R5 fault address" : "R4 physical address",
              rsp_paddr, exp_pa);
        if (exp_fault)
            check(rsp_fault_kind == exp_kind, exp_kind ? "R6 protection cause" : "R5 absent cause",
                  32'(rsp_fault_kind), 32'(exp_kind));
        req_valid = 1'b0;
        @(negedge clk);
        check(rsp_valid == 1'b0 && req_ready == 1'b1, "R9 pulse ends, idle",
              {30'b0, rsp_valid, req_ready}, 32'h1);
        check(mem_req_valid == 1'b0, "R8 held request started nothing", 32'(mem_req_valid), 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(req_ready == 1'b1, "R1 reset ready", 32'(req_ready), 32'h1);
        check(rsp_valid == 1'b0, "R1 reset response", 32'(rsp_valid), 32'h0);
        check(mem_req_valid == 1'b0, "R1 reset read", 32'(mem_req_valid), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int r = 0; r < 2; r++) begin
            root_frame = (r == 0) ? 20'h00001 : 20'hFFFFF;
            for (int i = 0; i < 1024; i += 31) begin
                for (int w = 0; w < 2; w++) begin
                    walk(i, 0, logic'(w));
                    walk(i, 1, logic'(w));
                    walk(i, 2, logic'(w));
                    walk(i, 4, logic'(w));
                    walk(i, 511, logic'(w));
                    walk(i, (i * 7) % 1024, logic'(w));
                    walk(i, 1023, logic'(w));
                end
            end
            for (int w = 0; w < 2; w++) begin
                for (int j = 0; j < 15; j++) walk(1023, j, logic'(w));
                walk(1022, 1023, logic'(w));
                walk(1021, 1022, logic'(w));
            end
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule